// File: doc/BRIEF.md
# Pseudo-random byte loopback error checker

This block measures the byte error rate of an external link that is wired as a loop. Its transmit half is an 8-bit pseudo-random generator whose current value drives the link. The generator can be loaded with a seed and stepped once per byte. The receive half never needs to know that seed. It takes the first byte that comes back as the seed of its own predictor. From then on it predicts every following byte, compares each arrival with the prediction, and counts compared samples and mismatching samples.

A host programs a target sample count. When the compared total reaches that count, the counters freeze and a done flag rises, so the error rate is simply the fail count over the target. If the seed byte itself was corrupted, every later prediction is wrong. To recover, the checker drops lock after a programmable number of back-to-back mismatches and seeds itself again from the next byte. A resync counter records each such event. A synchronous clear restarts the measurement without touching the transmit generator.

Top module: `prbs_loop_checker`

## Requirements
- R1: After reset, tx_byte is 0x01, and locked, done, fail_ovf, total_cnt, fail_cnt and resync_cnt are all zero.
- R2: The generator steps as next = {s[6:0], s[7]^s[5]^s[4]^s[3]}, where s[7] is the MSB; this is the polynomial x^8+x^6+x^5+x^4+1. tx_load loads tx_seed, with a seed of 0x00 replaced by 0x01. tx_step advances one step. tx_load wins over tx_step. The new value shows on tx_byte one cycle after the edge.
- R3: fail_cnt saturates at its all-ones value. A mismatch that arrives while it is all-ones sets fail_ovf, which stays set until clear or reset.
- R4: While unlocked, a valid byte loads the predictor as a seed (0x00 becomes 0x01) and sets locked. It is not counted in total_cnt or fail_cnt.
- R5: While locked, each valid byte is compared with the next generator step of the predictor. total_cnt increments by 1, and fail_cnt increments by 1 on a mismatch. The predictor takes the stepped value whether or not the byte matched.
- R6: A cycle with rx_valid low changes no receive-side output.
- R7: When fail_limit is non-zero and the count of consecutive mismatches reaches fail_limit, locked drops and resync_cnt increments. A matching byte restarts the run. fail_limit = 0 disables resync.
- R8: When target_total is non-zero and total_cnt becomes equal to it, done rises. While done is high, valid bytes change no counter and no lock state. target_total = 0 never sets done.
- R9: clear returns locked, done, fail_ovf and all three counters to zero on the next edge. It overrides a valid byte in the same cycle and leaves tx_byte unchanged.
- R10: The receive side follows the generator's own sequence when tx_byte is looped to rx_byte while stepping, and then records no failures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_load | input | 1 | Load tx_seed into the transmit generator |
| tx_seed | input | 8 | Transmit seed value |
| tx_step | input | 1 | Advance the transmit generator one step |
| tx_byte | output | 8 | Current transmit pattern byte |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| clear | input | 1 | Restart the measurement |
| fail_limit | input | RUN_W | Consecutive mismatches that trigger a reseed (0 = never) |
| target_total | input | TOTAL_W | Compared-sample count that ends the test (0 = never) |
| locked | output | 1 | Predictor is seeded and tracking |
| total_cnt | output | TOTAL_W | Compared samples |
| fail_cnt | output | FAIL_W | Mismatching samples (saturating) |
| fail_ovf | output | 1 | Sticky fail counter overflow |
| resync_cnt | output | RSYNC_W | Number of reseed events (saturating) |
| done | output | 1 | Target sample count reached |

## Verification
A clean loopback of the block's own transmit stream with idle gaps shows that seeding and prediction agree, and that gaps are ignored. Isolated single-bit flips stay below the fail limit, so they raise the fail count without causing a reseed. A run of wrong predictions caused by a corrupted seed byte instead triggers exactly one reseed followed by clean tracking. A zero seed byte, a stream that always mismatches with the resync disabled (driving the reduced-width fail counter into overflow), a reached target with extra bytes afterwards, and a clear that coincides with a valid byte each isolate one corner.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
  localparam int BYTE_W = 8;
  // feedback taps: bits 7,5,4,3 -> x^8+x^6+x^5+x^4+1
  localparam logic [BYTE_W-1:0] TAP_MASK = 8'hB8;
  localparam logic [BYTE_W-1:0] SAFE_SEED = 8'h01;

  function automatic logic [BYTE_W-1:0] lfsr_next(input logic [BYTE_W-1:0] s);
    return {s[BYTE_W-2:0], ^(s & TAP_MASK)};
  endfunction

  function automatic logic [BYTE_W-1:0] seed_fix(input logic [BYTE_W-1:0] s);
    return (s == '0) ? SAFE_SEED : s;
  endfunction
endpackage

// File: rtl/prbs_lfsr_gen.sv
module prbs_lfsr_gen
  import prbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] seed,
  input  logic              step,
  output logic [BYTE_W-1:0] state
);
  always_ff @(posedge clk) begin
    if (rst)       state <= SAFE_SEED;
    else if (load) state <= seed_fix(seed);
    else if (step) state <= lfsr_next(state);
  end
endmodule

// File: rtl/prbs_sync_ctrl.sv
module prbs_sync_ctrl #(
  parameter int RUN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             take,
  input  logic             mismatch,
  input  logic [RUN_W-1:0] fail_limit,
  output logic             locked,
  output logic             seed_load,
  output logic             pred_step,
  output logic             fail_event,
  output logic             resync_event
);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_inc;

  always_comb begin
    run_inc      = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
    seed_load    = take && !locked;
    pred_step    = take && locked;
    fail_event   = pred_step && mismatch;
    resync_event = fail_event && (fail_limit != '0) && (run_inc >= fail_limit);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      locked <= 1'b0;
      run_q  <= '0;
    end else if (seed_load) begin
      locked <= 1'b1;
      run_q  <= '0;
    end else if (pred_step) begin
      if (resync_event) begin
        locked <= 1'b0;
        run_q  <= '0;
      end else if (mismatch) begin
        run_q  <= run_inc;
      end else begin
        run_q  <= '0;
      end
    end
  end
endmodule

// File: rtl/prbs_err_count.sv
module prbs_err_count #(
  parameter int FAIL_W  = 32,
  parameter int TOTAL_W = 40,
  parameter int RSYNC_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               cmp_event,
  input  logic               fail_event,
  input  logic               resync_event,
  input  logic [TOTAL_W-1:0] target_total,
  output logic [TOTAL_W-1:0] total_cnt,
  output logic [FAIL_W-1:0]  fail_cnt,
  output logic               fail_ovf,
  output logic [RSYNC_W-1:0] resync_cnt,
  output logic               done
);
  logic [TOTAL_W-1:0] total_inc;
  assign total_inc = total_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      total_cnt  <= '0;
      fail_cnt   <= '0;
      fail_ovf   <= 1'b0;
      resync_cnt <= '0;
      done       <= 1'b0;
    end else begin
      if (cmp_event) begin
        total_cnt <= total_inc;
        if ((target_total != '0) && (total_inc == target_total)) done <= 1'b1;
      end
      if (fail_event) begin
        if (&fail_cnt) fail_ovf <= 1'b1;
        else           fail_cnt <= fail_cnt + 1'b1;
      end
      if (resync_event && !(&resync_cnt)) resync_cnt <= resync_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/prbs_loop_checker.sv
module prbs_loop_checker
  import prbs_pkg::*;
#(
  parameter int FAIL_W  = 32,
  parameter int TOTAL_W = 40,
  parameter int RSYNC_W = 16,
  parameter int RUN_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tx_load,
  input  logic [7:0]         tx_seed,
  input  logic               tx_step,
  output logic [7:0]         tx_byte,
  input  logic               rx_valid,
  input  logic [7:0]         rx_byte,
  input  logic               clear,
  input  logic [RUN_W-1:0]   fail_limit,
  input  logic [TOTAL_W-1:0] target_total,
  output logic               locked,
  output logic [TOTAL_W-1:0] total_cnt,
  output logic [FAIL_W-1:0]  fail_cnt,
  output logic               fail_ovf,
  output logic [RSYNC_W-1:0] resync_cnt,
  output logic               done
);
  logic [BYTE_W-1:0] pred_q;
  logic [BYTE_W-1:0] expect_b;
  logic take, mismatch, seed_load, pred_step, fail_event, resync_event;

  prbs_lfsr_gen u_tx_gen (
    .clk(clk), .rst(rst), .load(tx_load), .seed(tx_seed),
    .step(tx_step), .state(tx_byte)
  );

  assign take     = rx_valid && !done && !clear;
  assign expect_b = lfsr_next(pred_q);
  assign mismatch = (rx_byte != expect_b);

  prbs_lfsr_gen u_rx_pred (
    .clk(clk), .rst(rst), .load(seed_load), .seed(rx_byte),
    .step(pred_step), .state(pred_q)
  );

  prbs_sync_ctrl #(.RUN_W(RUN_W)) u_sync (
    .clk(clk), .rst(rst), .clear(clear), .take(take), .mismatch(mismatch),
    .fail_limit(fail_limit), .locked(locked), .seed_load(seed_load),
    .pred_step(pred_step), .fail_event(fail_event), .resync_event(resync_event)
  );

  prbs_err_count #(.FAIL_W(FAIL_W), .TOTAL_W(TOTAL_W), .RSYNC_W(RSYNC_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(clear), .cmp_event(pred_step),
    .fail_event(fail_event), .resync_event(resync_event),
    .target_total(target_total), .total_cnt(total_cnt), .fail_cnt(fail_cnt),
    .fail_ovf(fail_ovf), .resync_cnt(resync_cnt), .done(done)
  );
endmodule

// File: rtl/prbs_loop_checker_sva.sv
module prbs_loop_checker_sva #(
  parameter int FAIL_W  = 32,
  parameter int TOTAL_W = 40
) (
  input logic               clk,
  input logic               rst,
  input logic               clear,
  input logic               rx_valid,
  input logic               tx_load,
  input logic [7:0]         tx_byte,
  input logic               locked,
  input logic [TOTAL_W-1:0] total_cnt,
  input logic [FAIL_W-1:0]  fail_cnt,
  input logic               fail_ovf,
  input logic               done
);
  // R3: overflow flag is sticky
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (fail_ovf && !clear) |=> fail_ovf);

  // R5: failures never outnumber compared samples
  p_fail_le_total_r5: assert property (@(posedge clk) disable iff (rst)
    64'(fail_cnt) <= 64'(total_cnt));

  // R4: a seed byte locks and is not counted
  p_seed_uncounted_r4: assert property (@(posedge clk) disable iff (rst)
    (!locked && rx_valid && !clear && !done) |=> (locked && $stable(total_cnt) && $stable(fail_cnt)));

  // R6: idle cycles leave the receive side alone
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!rx_valid && !clear) |=> ($stable(total_cnt) && $stable(fail_cnt) && $stable(locked)));

  // R8: counters freeze once done
  p_done_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !clear) |=> (done && $stable(total_cnt) && $stable(fail_cnt)));

  // R9: clear restarts the measurement
  p_clear_restart_r9: assert property (@(posedge clk) disable iff (rst)
    clear |=> (total_cnt == '0 && fail_cnt == '0 && !locked && !done && !fail_ovf));

  // R2: the generator never holds the all-zero state after a load
  p_no_zero_seed_r2: assert property (@(posedge clk) disable iff (rst)
    tx_load |=> (tx_byte != 8'h00));
endmodule

bind prbs_loop_checker prbs_loop_checker_sva #(.FAIL_W(FAIL_W), .TOTAL_W(TOTAL_W)) u_sva (
  .clk(clk), .rst(rst), .clear(clear), .rx_valid(rx_valid), .tx_load(tx_load),
  .tx_byte(tx_byte), .locked(locked), .total_cnt(total_cnt), .fail_cnt(fail_cnt),
  .fail_ovf(fail_ovf), .done(done)
);

// File: tb/tb_prbs_loop_checker.sv
`timescale 1ns/1ps
module tb_prbs_loop_checker;
  localparam int FW = 4;
  localparam int TW = 40;
  localparam int RW = 16;
  localparam int FMAX = (1 << FW) - 1;

  logic clk = 0, rst = 1;
  logic tx_load = 0, tx_step = 0, rx_valid = 0, clear = 0;
  logic [7:0] tx_seed = 0, rx_byte = 0, fail_limit = 0;
  logic [TW-1:0] target_total = 0;
  logic [7:0] tx_byte;
  logic locked, fail_ovf, done;
  logic [TW-1:0] total_cnt;
  logic [FW-1:0] fail_cnt;
  logic [RW-1:0] resync_cnt;

  prbs_loop_checker #(.FAIL_W(FW), .TOTAL_W(TW), .RSYNC_W(RW), .RUN_W(8)) dut (
    .clk(clk), .rst(rst), .tx_load(tx_load), .tx_seed(tx_seed), .tx_step(tx_step),
    .tx_byte(tx_byte), .rx_valid(rx_valid), .rx_byte(rx_byte), .clear(clear),
    .fail_limit(fail_limit), .target_total(target_total), .locked(locked),
    .total_cnt(total_cnt), .fail_cnt(fail_cnt), .fail_ovf(fail_ovf),
    .resync_cnt(resync_cnt), .done(done)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  // reference model state
  bit [7:0] m_tx = 8'h01, m_pred = 8'h01;
  bit m_locked = 0, m_ovf = 0, m_done = 0;
  longint m_total = 0, m_fail = 0, m_rs = 0, m_run = 0;

  function automatic bit [7:0] mstep(bit [7:0] v);
    bit fb;
    fb = v[7] ^ v[5] ^ v[4] ^ v[3];
    return {v[6:0], fb};
  endfunction

  function automatic bit [7:0] mfix(bit [7:0] v);
    return (v == 0) ? 8'h01 : v;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_update;
    bit [7:0] e;
    if (rst) begin
      m_tx = 8'h01; m_pred = 8'h01; m_locked = 0; m_ovf = 0; m_done = 0;
      m_total = 0; m_fail = 0; m_rs = 0; m_run = 0;
      return;
    end
    if (tx_load) m_tx = mfix(tx_seed);
    else if (tx_step) m_tx = mstep(m_tx);
    if (clear) begin
      m_locked = 0; m_ovf = 0; m_done = 0; m_total = 0; m_fail = 0; m_rs = 0; m_run = 0;
    end else if (rx_valid && !m_done) begin
      if (!m_locked) begin
        m_pred = mfix(rx_byte); m_locked = 1; m_run = 0;
      end else begin
        e = mstep(m_pred);
        m_pred = e;
        m_total++;
        if (rx_byte != e) begin
          if (m_fail == FMAX) m_ovf = 1; else m_fail++;
          m_run++;
          if (fail_limit != 0 && m_run >= fail_limit) begin
            m_locked = 0; m_run = 0; m_rs++;
          end
        end else m_run = 0;
        if (target_total != 0 && m_total == target_total) m_done = 1;
      end
    end
  endtask

  task automatic compare_all;
    chk(tx_byte == m_tx, "R2 tx_byte", tx_byte, m_tx);
    chk(locked == m_locked, "R4/R7 locked", locked, m_locked);
    chk(total_cnt == m_total, "R5 total_cnt", total_cnt, m_total);
    chk(fail_cnt == m_fail, "R5 fail_cnt", fail_cnt, m_fail);
    chk(fail_ovf == m_ovf, "R3 fail_ovf", fail_ovf, m_ovf);
    chk(resync_cnt == m_rs, "R7 resync_cnt", resync_cnt, m_rs);
    chk(done == m_done, "R8 done", done, m_done);
  endtask

  task automatic tick;
    model_update();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  // loopback: send current tx byte, optionally flipped, and step the generator
  task automatic loop_send(bit [7:0] flip);
    rx_valid = 1; rx_byte = m_tx ^ flip; tx_step = 1;
    tick();
    rx_valid = 0; tx_step = 0;
  endtask

  task automatic send(bit [7:0] b);
    rx_valid = 1; rx_byte = b;
    tick();
    rx_valid = 0;
  endtask

  task automatic do_clear;
    clear = 1; tick(); clear = 0;
  endtask

  initial begin
    @(negedge clk);
    rst = 1; tick(); tick(); rst = 0;
    // R1 reset state
    chk(tx_byte == 8'h01 && !locked && !done && !fail_ovf && total_cnt == 0 && fail_cnt == 0 && resync_cnt == 0,
        "R1 reset state", tx_byte, 1);

    // R2 generator load and step
    tx_seed = 8'h5A; tx_load = 1; tick(); tx_load = 0;
    chk(tx_byte == 8'h5A, "R2 load", tx_byte, 8'h5A);
    tx_step = 1; tick(); tx_step = 0;
    chk(tx_byte == 8'hB4, "R2 one step", tx_byte, 8'hB4);
    tx_seed = 8'h00; tx_load = 1; tx_step = 1; tick(); tx_load = 0; tx_step = 0;
    chk(tx_byte == 8'h01, "R2 zero seed fixed, load wins", tx_byte, 1);
    for (int i = 0; i < 5; i++) begin tx_step = 1; tick(); end
    tx_step = 0;

    // R10/R6 clean loopback with idle gaps
    fail_limit = 3;
    tx_seed = 8'hA7; tx_load = 1; tick(); tx_load = 0;
    for (int i = 0; i < 24; i++) begin
      loop_send(8'h00);
      if (i % 5 == 2) begin tick(); tick(); end
    end
    chk(fail_cnt == 0 && total_cnt == 23, "R10 clean loop", fail_cnt, 0);

    // R5 isolated flips below the limit
    for (int i = 0; i < 20; i++) loop_send((i % 6 == 3) ? 8'h10 : 8'h00);
    chk(resync_cnt == 0, "R7 isolated flips no resync", resync_cnt, 0);
    chk(fail_cnt == m_fail && m_fail > 0, "R5 isolated flips counted", fail_cnt, m_fail);

    // R7 corrupted seed then recovery
    do_clear();
    loop_send(8'hFF);
    for (int i = 0; i < 10; i++) loop_send(8'h00);
    chk(fail_cnt == 3, "R7 fails before reseed", fail_cnt, 3);
    chk(resync_cnt == 1 && locked, "R7 one reseed, relocked", resync_cnt, 1);

    // R4 zero seed byte
    do_clear();
    send(8'h00);
    chk(locked && total_cnt == 0, "R4 seed uncounted", total_cnt, 0);
    send(8'h02);
    send(8'h04);
    chk(fail_cnt == 0 && total_cnt == 2, "R4 zero seed becomes 0x01", fail_cnt, 0);

    // R3 overflow with resync disabled
    do_clear();
    fail_limit = 0;
    send(8'h33);
    for (int i = 0; i < 20; i++) send(mstep(m_pred) ^ 8'h01);
    chk(fail_cnt == FMAX && fail_ovf, "R3 saturate and overflow", fail_cnt, FMAX);
    chk(resync_cnt == 0 && locked, "R7 limit zero disables resync", resync_cnt, 0);

    // R8 target reached then frozen
    fail_limit = 3;
    target_total = 10;
    do_clear();
    for (int i = 0; i < 14; i++) loop_send(8'h00);
    chk(done && total_cnt == 10, "R8 done at target", total_cnt, 10);
    loop_send(8'h40);
    chk(fail_cnt == 0 && total_cnt == 10, "R8 frozen after done", fail_cnt, 0);

    // R9 clear overrides a valid byte
    target_total = 0;
    rx_valid = 1; rx_byte = 8'h12; clear = 1; tick(); clear = 0; rx_valid = 0;
    chk(!locked && !done && total_cnt == 0, "R9 clear wins", locked, 0);
    tick();
    chk(!locked, "R6 idle leaves unlocked", locked, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule